// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card clock from a base clock. Software programs an 8-bit ratio field in bits [15:8] of a 16-bit clock control word. The field is a one-hot code: setting bit i divides the base clock by 2^(i+1), giving ratios from 2 to 256. All zeros passes the base clock straight through. If several bits are set, the most significant one decides the ratio. The output frequency is the base clock frequency divided by the selected ratio.

A change of ratio takes effect only at the end of a high phase of the SD clock, so the output never carries a shortened pulse. An external enable input starts the SD clock and stops it in its low state. A status bit, readable in bit 3 of the control word and also on its own output, shows when the clock is running at the programmed ratio. This bit clears when the ratio field is written, and it sets again once one full output period has completed at the new ratio.

Top module: `sdclk_divider`

## Requirements
- R1: A write (cfg_wr_en high at a rising edge of clk_base) stores cfg_wr_data[15:8] as the ratio field. The field reads back on cfg_rd_data[15:8] from the next cycle and resets to 00h.
- R2: With exactly one bit i of the ratio field set, sd_clk is a square wave with a period of 2^(i+1) base cycles and a high phase of 2^i base cycles.
- R3: With the ratio field at 00h and the enable high, sd_clk follows clk_base: high during each high phase of the base clock and low during each low phase.
- R4: With more than one bit set, the ratio is the one given by the most significant set bit alone. For example 5Ah divides by 128 and FFh divides by 256.
- R5: cfg_rd_data[7:4] and cfg_rd_data[2:0] always read 0. Bit 3 is read-only status, and writing a 1 to it does not set it.
- R6: The status bit (cfg_rd_data[3] and clk_stable) is 0 after reset. It clears at the write edge. It sets at the second ratio boundary after the write: the first boundary loads the new ratio, and the second ends one full period at that ratio.
- R7: A new ratio, bypass or stop takes effect only at a boundary. In divided mode a boundary is the edge at which sd_clk falls. Every high phase of sd_clk therefore lasts exactly the half period of the ratio that was in force when the phase began.
- R8: While ext_clk_en is low, the status bit is 0 and sd_clk stops low at the next boundary. When ext_clk_en goes high again, the clock restarts at the programmed ratio.
- R9: While rst is high, sd_clk is low, the status bit is 0, the ratio field is 00h and the divider counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base clock the SD clock is derived from |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the clock control word |
| cfg_wr_data | input | 16 | Write data; bits [15:8] are the ratio field |
| ext_clk_en | input | 1 | External request to run the SD clock |
| cfg_rd_data | output | 16 | Control word read value: ratio field, status in bit 3, other bits 0 |
| sd_clk | output | 1 | SD card clock |
| clk_stable | output | 1 | Clock running at the programmed ratio |

## Verification
The assertions assume that the write strobe, the write data and the enable change only away from the rising edge of clk_base. They also assume that reset is held for at least one full base cycle, so the falling-edge gate register clears before the checks look at sd_clk. The bench drives every input half a nanosecond after a falling edge and holds reset for several cycles. It samples sd_clk in the middle of both base phases, so bypass mode can be seen at all. Writes are also issued at arbitrary points inside high phases, which exercises the deferred switch.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_BYP  = 2'd1,
    MODE_DIV  = 2'd2
  } sd_mode_e;
endpackage

// File: rtl/sdclk_sel_decode.sv
module sdclk_sel_decode #(
  parameter int SEL_W = 8,
  parameter int K_W   = $clog2(SEL_W + 1)
) (
  input  logic [SEL_W-1:0] sel,
  output logic [K_W-1:0]   ratio_k
);
  // ratio_k = index of highest set bit plus one, zero for an empty field
  logic [SEL_W-1:0] top_bit;

  genvar g;
  generate
    for (g = 0; g < SEL_W; g++) begin : g_top
      if (g == SEL_W - 1) begin : g_msb
        assign top_bit[g] = sel[g];
      end else begin : g_low
        assign top_bit[g] = sel[g] & ~(|sel[SEL_W-1:g+1]);
      end
    end
  endgenerate

  always_comb begin
    ratio_k = '0;
    for (int i = 0; i < SEL_W; i++) begin
      if (top_bit[i]) ratio_k = K_W'(i + 1);
    end
  end

  always_comb begin
    if (sel != '0) begin
      // R4
      top_bit_chk: assert (sel[ratio_k - K_W'(1)] && ((sel >> ratio_k) == '0));
    end
  end
endmodule

// File: rtl/sdclk_ratio_counter.sv
module sdclk_ratio_counter
  import sdclk_pkg::*;
#(
  parameter int SEL_W = 8,
  parameter int K_W   = $clog2(SEL_W + 1),
  parameter int CNT_W = (SEL_W > 1) ? SEL_W - 1 : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [K_W-1:0] tgt_k,
  output sd_mode_e       mode_q,
  output logic           div_q,
  output logic           at_bound
);
  logic [K_W-1:0]   act_k;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;

  // last count of a half period for the active ratio
  always_comb begin
    half_m1 = '0;
    if (act_k != '0) half_m1 = CNT_W'((32'd1 << (act_k - K_W'(1))) - 32'd1);
  end

  // a new setting may only be taken where the output is about to be low
  assign at_bound = (mode_q != MODE_DIV) || (div_q && (cnt_q == half_m1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_STOP;
      act_k  <= '0;
      cnt_q  <= '0;
      div_q  <= 1'b0;
    end else if (at_bound) begin
      cnt_q <= '0;
      div_q <= 1'b0;
      if (!en) begin
        mode_q <= MODE_STOP;
        act_k  <= '0;
      end else if (tgt_k == '0) begin
        mode_q <= MODE_BYP;
        act_k  <= '0;
      end else begin
        mode_q <= MODE_DIV;
        act_k  <= tgt_k;
      end
    end else if (cnt_q == half_m1) begin
      cnt_q <= '0;
      div_q <= ~div_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_DIV) |-> (cnt_q <= half_m1));

  // R7
  mode_switch_low_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(mode_q) == MODE_DIV) && (act_k != $past(act_k))) |-> ($past(div_q) && !div_q));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ((cnt_q == '0) && !div_q && (mode_q == MODE_STOP)));
endmodule

// File: rtl/sdclk_out_gate.sv
module sdclk_out_gate (
  input  logic clk,
  input  logic rst,
  input  logic byp_on,
  input  logic div_q,
  output logic sd_clk
);
  logic gate_q;

  // gate changes only while clk is low, so the bypass path never chops a pulse
  always_ff @(negedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= byp_on;
  end

  assign sd_clk = div_q | (clk & gate_q);

  // R9
  gate_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !gate_q);
endmodule

// File: rtl/sdclk_stable_track.sv
module sdclk_stable_track (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic en,
  input  logic at_bound,
  output logic stable_q
);
  logic [1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 2'd2;
      stable_q <= 1'b0;
    end else if (wr_en || !en) begin
      pend_q   <= 2'd2;
      stable_q <= 1'b0;
    end else if (at_bound && (pend_q != 2'd0)) begin
      pend_q <= pend_q - 2'd1;
      if (pend_q == 2'd1) stable_q <= 1'b1;
    end
  end

  // R6
  wr_clears_stable_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !stable_q);

  // R6
  stable_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stable_q) |-> ($past(at_bound) && $past(en) && !$past(wr_en)));
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int SEL_W    = 8,
  parameter int SEL_LSB  = 8,
  parameter int STAT_BIT = 3
) (
  input  logic             clk_base,
  input  logic             rst,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  input  logic             ext_clk_en,
  output logic [REG_W-1:0] cfg_rd_data,
  output logic             sd_clk,
  output logic             clk_stable
);
  localparam int K_W   = $clog2(SEL_W + 1);
  localparam int CNT_W = (SEL_W > 1) ? SEL_W - 1 : 1;

  logic [SEL_W-1:0] sel_q;
  logic [K_W-1:0]   ratio_k;
  sd_mode_e         mode_q;
  logic             div_q;
  logic             at_bound;
  logic             stable_q;

  always_ff @(posedge clk_base) begin
    if (rst)            sel_q <= '0;
    else if (cfg_wr_en) sel_q <= cfg_wr_data[SEL_LSB +: SEL_W];
  end

  sdclk_sel_decode #(.SEL_W(SEL_W), .K_W(K_W)) dec_i (
    .sel     (sel_q),
    .ratio_k (ratio_k)
  );

  sdclk_ratio_counter #(.SEL_W(SEL_W), .K_W(K_W), .CNT_W(CNT_W)) cnt_i (
    .clk      (clk_base),
    .rst      (rst),
    .en       (ext_clk_en),
    .tgt_k    (ratio_k),
    .mode_q   (mode_q),
    .div_q    (div_q),
    .at_bound (at_bound)
  );

  sdclk_out_gate gate_i (
    .clk    (clk_base),
    .rst    (rst),
    .byp_on (mode_q == MODE_BYP),
    .div_q  (div_q),
    .sd_clk (sd_clk)
  );

  sdclk_stable_track stat_i (
    .clk      (clk_base),
    .rst      (rst),
    .wr_en    (cfg_wr_en),
    .en       (ext_clk_en),
    .at_bound (at_bound),
    .stable_q (stable_q)
  );

  always_comb begin
    cfg_rd_data                     = '0;
    cfg_rd_data[SEL_LSB +: SEL_W]   = sel_q;
    cfg_rd_data[STAT_BIT]           = stable_q;
  end

  assign clk_stable = stable_q;

  // R1
  sel_update_chk: assert property (@(posedge clk_base) disable iff (rst)
    cfg_wr_en |=> (cfg_rd_data[SEL_LSB +: SEL_W] == $past(cfg_wr_data[SEL_LSB +: SEL_W])));

  // R8
  disabled_no_stable_chk: assert property (@(posedge clk_base) disable iff (rst)
    !ext_clk_en |=> !clk_stable);
endmodule

// File: tb/sdclk_divider_tb_top.sv
module sdclk_divider_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        en = 1'b0;
  logic [15:0] rd_data;
  logic        sd_clk;
  logic        clk_stable;

  sdclk_divider dut_i (
    .clk_base    (clk),
    .rst         (rst),
    .cfg_wr_en   (wr_en),
    .cfg_wr_data (wr_data),
    .ext_clk_en  (en),
    .cfg_rd_data (rd_data),
    .sd_clk      (sd_clk),
    .clk_stable  (clk_stable)
  );

  always #2.5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R9";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;

  // reference model: mode -1 stopped, 0 pass-through, k>0 divide by 2^k
  int m_mode = -1, m_cnt = 0, m_div = 0, m_sel = 0, m_pend = 2, m_stab = 0, m_gate = 0;

  function automatic int top_k(int s);
    int k = 0;
    for (int i = 0; i < 8; i++) if (s[i]) k = i + 1;
    return k;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = -1; m_cnt = 0; m_div = 0; m_sel = 0; m_pend = 2; m_stab = 0;
    end else begin
      int half;
      bit bnd;
      half = (m_mode > 0) ? (1 << (m_mode - 1)) : 1;
      bnd  = (m_mode <= 0) || (m_div == 1 && m_cnt == half - 1);
      if (bnd) begin
        m_cnt = 0; m_div = 0;
        m_mode = en ? top_k(m_sel) : -1;
      end else if (m_cnt == half - 1) begin
        m_cnt = 0; m_div = 1 - m_div;
      end else begin
        m_cnt++;
      end
      if (wr_en || !en) begin
        m_pend = 2; m_stab = 0;
      end else if (bnd && m_pend > 0) begin
        if (m_pend == 1) m_stab = 1;
        m_pend--;
      end
      if (wr_en) m_sel = int'(wr_data[15:8]);
    end
  end

  always @(negedge clk) m_gate = rst ? 0 : ((m_mode == 0) ? 1 : 0);

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (cmp_on && !done) chk("sd_clk in base high phase", int'(sd_clk), m_div | m_gate);
  end

  always @(negedge clk) begin
    #1.5;
    if (cmp_on && !done) begin
      chk("sd_clk in base low phase", int'(sd_clk), m_div);
      chk("clk_stable", int'(clk_stable), m_stab);
      chk("read word", int'(rd_data), (m_sel << 8) | (m_stab << 3));
    end
  end

  task automatic wr(logic [15:0] d);
    @(negedge clk); #0.5;
    wr_en = 1'b1; wr_data = d;
    @(negedge clk); #0.5;
    wr_en = 1'b0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic period_chk(int ratio);
    int hi = 0;
    int guard = 0;
    while (clk_stable !== 1'b1 && guard < 2000) begin
      @(negedge clk); #1.5; guard++;
    end
    chk("status set after one period", int'(clk_stable), 1);
    repeat (2 * ratio) begin
      @(negedge clk); #1.5;
      if (sd_clk) hi++;
    end
    chk("high samples over two periods", hi, ratio);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    cyc(4);
    @(negedge clk); #1.5;
    cur_req = "R9";
    chk("sd_clk in reset", int'(sd_clk), 0);
    chk("status in reset", int'(clk_stable), 0);
    chk("read word in reset", int'(rd_data), 0);
    @(negedge clk); #0.5;
    rst = 1'b0;
    cmp_on = 1'b1;

    cur_req = "R8";
    cyc(10);
    en = 1'b1;

    cur_req = "R3";
    cyc(4);
    repeat (8) begin
      @(posedge clk); #1; chk("pass-through high", int'(sd_clk), 1);
      @(negedge clk); #1.5; chk("pass-through low", int'(sd_clk), 0);
    end

    cur_req = "R2";
    for (int i = 0; i < 8; i++) begin
      wr(16'(1 << (i + 8)));
      period_chk(2 << i);
    end

    cur_req = "R4";
    wr(16'h5A00); period_chk(128);
    wr(16'hFF00); period_chk(256);
    wr(16'h0300); period_chk(4);

    cur_req = "R1";
    wr(16'hA500);
    @(negedge clk); #1.5;
    chk("ratio field readback", int'(rd_data[15:8]), 'hA5);
    period_chk(256);

    cur_req = "R5";
    wr(16'h00FF);
    @(negedge clk); #1.5;
    chk("reserved upper nibble", int'(rd_data[7:4]), 0);
    chk("status bit not writable", int'(rd_data[3]), 0);
    chk("low bits zero", int'(rd_data[2:0]), 0);
    cyc(6);

    cur_req = "R6";
    wr(16'h0800);
    #1;
    chk("status cleared by write", int'(clk_stable), 0);
    period_chk(16);

    cur_req = "R7";
    cyc(5);
    wr(16'h0100);
    cyc(3);
    wr(16'h4000);
    cyc(1);
    wr(16'h0000);
    cyc(9);
    wr(16'h0200);
    period_chk(4);
    cyc(7);
    wr(16'h2000);
    period_chk(64);

    cur_req = "R8";
    wr(16'h0400);
    period_chk(8);
    @(negedge clk); #0.5;
    en = 1'b0;
    cyc(20);
    repeat (10) begin
      @(posedge clk); #1; chk("stopped high phase", int'(sd_clk), 0);
      @(negedge clk); #1.5; chk("stopped low phase", int'(sd_clk), 0);
      chk("status while stopped", int'(clk_stable), 0);
    end
    @(negedge clk); #0.5;
    en = 1'b1;
    period_chk(8);

    cur_req = "R9";
    cyc(3);
    @(negedge clk); #0.5;
    rst = 1'b1;
    cyc(3);
    @(negedge clk); #1.5;
    chk("sd_clk after mid-run reset", int'(sd_clk), 0);
    chk("status after mid-run reset", int'(clk_stable), 0);
    chk("read word after mid-run reset", int'(rd_data), 0);
    @(negedge clk); #0.5;
    rst = 1'b0;
    cyc(6);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL %s watchdog: actual %0d expected %0d", cur_req, 1, 0);
      summary();
      $finish;
    end
  end
endmodule